// File: doc/BRIEF.md
# Dual-Port RAM with Collision Flag

A synchronous random-access memory with two ports, A and B, that work fully independently. Each port has its own enable, write enable, address, write data and registered read data. So one clock cycle can carry two reads, two writes, or one read and one write, at any pair of addresses.

Neither port has priority over the other. If both ports write the same address in the same cycle, the word stored there is treated as undefined. The block flags the event on a one-cycle collision pulse. Each word has a validity flag, and a collision clears it. A later read of that word raises the reading port's invalid indication next to the returned data. The flag stays clear until a single port writes the word again.

Each port reads first. When a port writes, its read output carries the word that was at that address before the write. Reset clears every word to zero and marks every word valid.

Top module: `twin_port_ram`

## Requirements
- R1: During and after a synchronous active-high reset, both read outputs are zero, both invalid indications are low and the collision pulse is low. Every word reads back as zero and valid.
- R2: When a port's enable and write enable are both high at a clock edge, and the other port is not writing the same address, its write data is stored at its address.
- R3: When a port's enable is high at a clock edge, that port's read output shows the word stored at its address just before that edge, from the cycle after the edge.
- R4: A port that writes shows the previous content of the written address on its own read output (read-first), not the new data.
- R5: The collision output is high for exactly the one cycle after an edge at which both ports had enable and write enable high with equal addresses. It is low after every other edge.
- R6: A collision marks that address invalid. A read of an invalid address sets that port's invalid indication to 1 alongside the (unspecified) data word.
- R7: A write by a single port to an invalid address makes it valid again. Later reads return the written word with the invalid indication at 0.
- R8: While a port's enable is low, its read output and invalid indication hold their values, and its write enable has no effect on the stored words.
- R9: Two writes to different addresses in the same cycle both take effect.
- R10: When one port reads an address that the other port writes at the same edge, the reading port gets the old word and the old validity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW (6) | Port A word address |
| a_wdata | input | DW (16) | Port A write data |
| a_rdata | output | DW (16) | Port A registered read data |
| a_bad | output | 1 | Port A read address was invalid |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW (6) | Port B word address |
| b_wdata | input | DW (16) | Port B write data |
| b_rdata | output | DW (16) | Port B registered read data |
| b_bad | output | 1 | Port B read address was invalid |
| clash | output | 1 | One-cycle pulse after a same-address double write |

## Verification
A corrupted word or a misplaced write stays hidden until some port reads that address. At that point it shows up one cycle after the read edge, as a wrong read word. A wrong validity flag shows the same way, on the invalid indication. A missed or false same-address compare shows on the collision pulse one cycle after the offending edge. It also shows on the next read of that address as a wrong invalid indication. The bench narrows random addresses to a small window so that collisions, cross-port read-during-write and re-validation all happen often and get read back soon after.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic acc_e classify(input logic en, input logic we);
        if (!en)      return ACC_IDLE;
        else if (we)  return ACC_WRITE;
        else          return ACC_READ;
    endfunction

endpackage

// File: rtl/tpr_clash.sv
module tpr_clash #(
    parameter int AW = 6
) (
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    output logic          a_wr,
    output logic          b_wr,
    output logic          hit
);
    import tpr_pkg::*;

    acc_e a_acc, b_acc;

    always_comb begin
        a_acc = classify(a_en, a_we);
        b_acc = classify(b_en, b_we);
        a_wr  = (a_acc == ACC_WRITE);
        b_wr  = (b_acc == ACC_WRITE);
        hit   = a_wr && b_wr && (a_addr == b_addr);
    end

endmodule

// File: rtl/tpr_rdport.sv
module tpr_rdport #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] word,
    input  logic          ok,
    output logic [DW-1:0] rdata,
    output logic          bad
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          bad;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.data = word;
            st_d.bad  = !ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.data;
    assign bad   = st_q.bad;

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     a_en,
    input  logic                     a_we,
    input  logic [$clog2(DEPTH)-1:0] a_addr,
    input  logic [DW-1:0]            a_wdata,
    output logic [DW-1:0]            a_rdata,
    output logic                     a_bad,
    input  logic                     b_en,
    input  logic                     b_we,
    input  logic [$clog2(DEPTH)-1:0] b_addr,
    input  logic [DW-1:0]            b_wdata,
    output logic [DW-1:0]            b_rdata,
    output logic                     b_bad,
    output logic                     clash
);
    localparam int AW     = $clog2(DEPTH);
    localparam int NPORTS = 2;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] word;
        logic [DEPTH-1:0]         ok;
        logic                     clash;
    } ram_st_t;

    ram_st_t st_d, st_q;

    logic a_wr, b_wr, hit;

    tpr_clash #(.AW(AW)) u_clash (
        .a_en   (a_en),
        .a_we   (a_we),
        .a_addr (a_addr),
        .b_en   (b_en),
        .b_we   (b_we),
        .b_addr (b_addr),
        .a_wr   (a_wr),
        .b_wr   (b_wr),
        .hit    (hit)
    );

    // Per-port views so the read side can be generated
    logic [NPORTS-1:0]         p_en;
    logic [NPORTS-1:0][AW-1:0] p_addr;
    logic [NPORTS-1:0][DW-1:0] p_rdata;
    logic [NPORTS-1:0]         p_bad;

    assign p_en   = {b_en, a_en};
    assign p_addr = {b_addr, a_addr};

    // Next state of the array: the read side sees st_q, so reads are read-first
    always_comb begin
        st_d       = st_q;
        st_d.clash = hit;
        if (hit) begin
            st_d.word[a_addr] = a_wdata;
            st_d.ok[a_addr]   = 1'b0;
        end else begin
            if (a_wr) begin
                st_d.word[a_addr] = a_wdata;
                st_d.ok[a_addr]   = 1'b1;
            end
            if (b_wr) begin
                st_d.word[b_addr] = b_wdata;
                st_d.ok[b_addr]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.word  <= '0;
            st_q.ok    <= '1;
            st_q.clash <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        tpr_rdport #(.DW(DW)) u_rd (
            .clk   (clk),
            .rst   (rst),
            .en    (p_en[p]),
            .word  (st_q.word[p_addr[p]]),
            .ok    (st_q.ok[p_addr[p]]),
            .rdata (p_rdata[p]),
            .bad   (p_bad[p])
        );
    end

    assign a_rdata = p_rdata[0];
    assign a_bad   = p_bad[0];
    assign b_rdata = p_rdata[1];
    assign b_bad   = p_bad[1];
    assign clash   = st_q.clash;

endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_rdata,
    input logic          a_bad,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_rdata,
    input logic          b_bad,
    input logic          clash
);
    // R5: a same-address double write yields the pulse
    a_r5_clash_raised: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && b_en && b_we && a_addr == b_addr) |=> clash);

    // R5: the pulse never appears without a same-address double write
    a_r5_clash_cause: assert property (@(posedge clk) disable iff (rst)
        clash |-> $past(a_en && a_we && b_en && b_we && a_addr == b_addr));

    // R8: port A output holds while disabled
    a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> ($stable(a_rdata) && $stable(a_bad)));

    // R8: port B output holds while disabled
    a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> ($stable(b_rdata) && $stable(b_bad)));

    // R1: outputs are quiet the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (a_rdata == '0 && b_rdata == '0 && !a_bad && !b_bad && !clash));

endmodule

bind twin_port_ram tpr_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_rdata (a_rdata),
    .a_bad   (a_bad),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_rdata (b_rdata),
    .b_bad   (b_bad),
    .clash   (clash)
);

// File: tb/sim_twin_port_ram.sv
`timescale 1ns/1ps
module sim_twin_port_ram;
    localparam int DW    = 16;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_bad, b_bad, clash;

    always #5 clk = ~clk;

    twin_port_ram #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_bad(a_bad),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_bad(b_bad),
        .clash(clash)
    );

    // Reference model
    logic [DW-1:0] m_word [DEPTH];
    logic          m_ok   [DEPTH];
    logic [DW-1:0] e_a_d = '0, e_b_d = '0;
    logic          e_a_i = 0, e_b_i = 0, e_clash = 0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic void chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic void compare_all(string tag);
        chk(tag, "a_bad", DW'(a_bad), DW'(e_a_i));
        if (!e_a_i) chk(tag, "a_rdata", a_rdata, e_a_d);
        chk(tag, "b_bad", DW'(b_bad), DW'(e_b_i));
        if (!e_b_i) chk(tag, "b_rdata", b_rdata, e_b_d);
        chk(tag, "clash", DW'(clash), DW'(e_clash));
    endfunction

    // Drive one cycle (called just after a falling edge), update model, sample at next falling edge
    task automatic step(string tag,
                        logic ae, logic awe, logic [AW-1:0] aa, logic [DW-1:0] ad,
                        logic be, logic bwe, logic [AW-1:0] ba, logic [DW-1:0] bd);
        logic aw, bw, hit;
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        aw  = ae && awe;
        bw  = be && bwe;
        hit = aw && bw && (aa == ba);
        if (ae) begin e_a_d = m_word[aa]; e_a_i = !m_ok[aa]; end
        if (be) begin e_b_d = m_word[ba]; e_b_i = !m_ok[ba]; end
        e_clash = hit;
        if (hit) begin
            m_ok[aa] = 1'b0;
        end else begin
            if (aw) begin m_word[aa] = ad; m_ok[aa] = 1'b1; end
            if (bw) begin m_word[ba] = bd; m_ok[ba] = 1'b1; end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin m_word[i] = '0; m_ok[i] = 1'b1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1 in reset");
        rst = 1'b0;
        // R1: every word zero and valid after reset
        step("R1", 1, 0, 6'd5, 16'h0, 1, 0, 6'd63, 16'h0);
        // R2 / R3: write A, read back on B
        step("R2", 1, 1, 6'd3, 16'h1234, 0, 0, 6'd0, 16'h0);
        step("R3", 0, 0, 6'd0, 16'h0, 1, 0, 6'd3, 16'h0);
        // R4: read-first on the writing port
        step("R4", 1, 1, 6'd3, 16'hBEEF, 0, 0, 6'd0, 16'h0);
        step("R4 readback", 1, 0, 6'd3, 16'h0, 0, 0, 6'd0, 16'h0);
        // R5 / R6: same-address double write
        step("R5", 1, 1, 6'd10, 16'hAAAA, 1, 1, 6'd10, 16'h5555);
        step("R6", 1, 0, 6'd10, 16'h0, 1, 0, 6'd10, 16'h0);
        // R7: single write restores validity
        step("R7 write", 0, 0, 6'd0, 16'h0, 1, 1, 6'd10, 16'h7777);
        step("R7", 1, 0, 6'd10, 16'h0, 0, 0, 6'd0, 16'h0);
        // R8: disabled port ignores write enable and holds output
        step("R8", 0, 1, 6'd3, 16'hDEAD, 0, 1, 6'd4, 16'hDEAD);
        step("R8 readback", 1, 0, 6'd3, 16'h0, 1, 0, 6'd4, 16'h0);
        // R9: two writes to different addresses
        step("R9", 1, 1, 6'd20, 16'h2020, 1, 1, 6'd21, 16'h2121);
        step("R9 readback", 1, 0, 6'd21, 16'h0, 1, 0, 6'd20, 16'h0);
        // R10: cross-port read during write
        step("R10", 1, 1, 6'd20, 16'hCAFE, 1, 0, 6'd20, 16'h0);
        step("R10 readback", 0, 0, 6'd0, 16'h0, 1, 0, 6'd20, 16'h0);
        // R10 with an invalid location being rewritten by the other port
        step("R10 clash", 1, 1, 6'd30, 16'h1111, 1, 1, 6'd30, 16'h2222);
        step("R10 old invalid", 1, 0, 6'd30, 16'h0, 1, 1, 6'd30, 16'h3333);
        step("R10 now valid", 1, 0, 6'd30, 16'h0, 0, 0, 6'd0, 16'h0);
        // Random traffic in a narrow address window (R3 R5 R6 R7)
        for (int k = 0; k < 4000; k++) begin
            logic [AW-1:0] ra, rb;
            ra = AW'($urandom % 8);
            rb = AW'($urandom % 8);
            step("R3 random",
                 ($urandom % 4) != 0, ($urandom % 2) == 1, ra, DW'($urandom),
                 ($urandom % 4) != 0, ($urandom % 2) == 1, rb, DW'($urandom));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule